// File: doc/BRIEF.md
# Sensor Code and Temperature Interpolating Converter

This block translates between a 12-bit thermal sensor code and a temperature in milli-degrees Celsius. It works in either direction. A fixed calibration table holds one point every 5 °C from -40 °C to 125 °C. Between two adjacent points the block interpolates linearly. A code beyond the top of the table saturates to 125 °C. A temperature above the table cannot be encoded, so the block returns the all-ones code and raises a failure flag.

A caller sets `to_code_i` to choose the direction, places the operand on `code_i` or `temp_i`, and pulses `req_i`. The block then scans the table one entry per cycle, starting at index 1. It forms the interpolation product and runs a restoring divide of fixed length. It finishes with a one-cycle `done_o`. Results stay on `temp_o`, `code_o` and `fail_o` until the next conversion of the same direction overwrites them.

Top module: `tsc_convert`

## Requirements
- R1: A code equal to a table code in 402..685 returns that entry's temperature exactly. Examples: 402 gives -40000, 470 gives 0, 685 gives 125000.
- R2: A code that lies strictly between two table codes returns prev_temp + floor(5000 * (code - prev_code) / (next_code - prev_code)). Examples: 474 gives 2500, 488 gives 10555.
- R3: Any code at or below 402 returns -40000. Any code above 685, up to 4095, returns 125000.
- R4: A temperature equal to a table temperature, that is a multiple of 5000 from -40000 to 125000, returns that entry's code exactly. Example: 0 gives 470.
- R5: A temperature that lies strictly between two table temperatures returns prev_code + floor((next_code - prev_code) * (temp - prev_temp) / 5000). Examples: 2500 gives 474, 9999 gives 486.
- R6: A temperature above 125000 sets `code_o` to 0xFFF and `fail_o` to 1. Every other temperature-to-code conversion sets `fail_o` to 0, and so does every code-to-temperature conversion.
- R7: A temperature below -40000 returns code 0.
- R8: After reset, `busy_o`, `done_o`, `fail_o`, `temp_o` and `code_o` are all zero. `busy_o` rises in the cycle after an accepted request and falls in the cycle in which `done_o` pulses for one cycle. A request that arrives while busy produces no result and no extra `done_o`.
- R9: `done_o` appears DIV_W+1+k cycles after the clock edge that accepts the request, where k is the table index at which the search stops. For example, with DIV_W=32, a code of 402 has k=1 and takes 34 cycles, a code of 685 has k=34 and takes 67 cycles, and an unencodable temperature has k=36 and takes 69 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start pulse, accepted only when idle |
| to_code_i | input | 1 | 0: code to temperature, 1: temperature to code |
| code_i | input | 12 | Sensor code operand |
| temp_i | input | 32 | Signed temperature operand in milli-°C |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| temp_o | output | 32 | Last code-to-temperature result, signed milli-°C |
| code_o | output | 12 | Last temperature-to-code result |
| fail_o | output | 1 | Last conversion could not be encoded |

## Verification
The hardest situation to reach is the flat first segment. There the two lowest table points share -40000, so the temperature span is zero, and the divider must not see a zero divisor. The stimulus reaches it with codes 0 and 100, and with temperatures -40001 and the most negative 32-bit value. The two ends of the search need the same care: code 4095 runs the scan past its last tested entry, and temperature 125001 runs it off the table entirely. The latency of both end cases is measured against a first-entry hit. A second request is also injected mid-conversion to show that it leaves both outputs untouched.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CODE_W  = 12;
  localparam int TEMP_W  = 32;
  localparam int N_ENT   = 36;
  localparam int IDX_W   = $clog2(N_ENT + 1);
  localparam int T_MIN   = -40000;
  localparam int T_MAX   = 125000;
  localparam int T_STEP  = 5000;

  // entry 0 and entry N_ENT-1 are clamp anchors
  function automatic logic [CODE_W-1:0] cal_code(input int i);
    case (i)
      0: return 12'd0;     1: return 12'd402;   2: return 12'd410;   3: return 12'd419;
      4: return 12'd427;   5: return 12'd436;   6: return 12'd444;   7: return 12'd453;
      8: return 12'd461;   9: return 12'd470;  10: return 12'd478;  11: return 12'd487;
     12: return 12'd496;  13: return 12'd504;  14: return 12'd513;  15: return 12'd521;
     16: return 12'd530;  17: return 12'd538;  18: return 12'd547;  19: return 12'd555;
     20: return 12'd564;  21: return 12'd573;  22: return 12'd581;  23: return 12'd590;
     24: return 12'd599;  25: return 12'd607;  26: return 12'd616;  27: return 12'd624;
     28: return 12'd633;  29: return 12'd642;  30: return 12'd650;  31: return 12'd659;
     32: return 12'd668;  33: return 12'd677;  34: return 12'd685;  35: return 12'hFFF;
      default: return 12'd0;
    endcase
  endfunction

  function automatic logic signed [TEMP_W-1:0] cal_temp(input int i);
    if (i <= 0)         return TEMP_W'(T_MIN);
    if (i >= N_ENT - 1) return TEMP_W'(T_MAX);
    return TEMP_W'(T_MIN + T_STEP * (i - 1));
  endfunction
endpackage

// File: rtl/tsc_cal_rom.sv
module tsc_cal_rom
  import tsc_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0]            idx_i,
  output logic [CODE_W-1:0]        cur_code_o,
  output logic signed [TEMP_W-1:0] cur_temp_o,
  output logic [CODE_W-1:0]        prv_code_o,
  output logic signed [TEMP_W-1:0] prv_temp_o
);
  always_comb begin
    cur_code_o = cal_code(int'(idx_i));
    cur_temp_o = cal_temp(int'(idx_i));
    prv_code_o = cal_code(int'(idx_i) - 1);
    prv_temp_o = cal_temp(int'(idx_i) - 1);
  end
endmodule

// File: rtl/tsc_divider.sv
module tsc_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(NUM_W);

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [DEN_W:0]   shifted, trial;
  logic             ge;

  assign shifted = {rem_q, q_q[NUM_W-1]};
  assign trial   = shifted - {1'b0, den_q};
  assign ge      = shifted >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
      q_q <= '0; rem_q <= '0; den_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1; cnt_q <= '0;
        q_q <= num_i; rem_q <= '0; den_q <= den_i;
      end else if (run_q) begin
        rem_q <= ge ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(NUM_W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;

  // restoring invariant keeps truncating quotient exact (R2, R5)
  p_rem_below_den_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> rem_q < den_q);
  p_no_zero_den_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> den_i != '0);
endmodule

// File: rtl/tsc_convert.sv
module tsc_convert
  import tsc_pkg::*;
#(
  parameter int DIV_W = TEMP_W,
  parameter int DEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              to_code_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [TEMP_W-1:0] temp_o,
  output logic [CODE_W-1:0] code_o,
  output logic              fail_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_DIV} st_e;

  st_e                      st_q;
  logic                     to_code_q, miss_q, done_q, fail_q;
  logic [CODE_W-1:0]        code_q, code_res_q;
  logic signed [TEMP_W-1:0] temp_q, base_q, temp_res_q;
  logic [IDX_W-1:0]         idx_q;

  logic [CODE_W-1:0]        cur_code, prv_code;
  logic signed [TEMP_W-1:0] cur_temp, prv_temp;

  tsc_cal_rom #(.IW(IDX_W)) u_rom (
    .idx_i(idx_q), .cur_code_o(cur_code), .cur_temp_o(cur_temp),
    .prv_code_o(prv_code), .prv_temp_o(prv_temp)
  );

  logic                     at_end, hit, exact, zspan, settle, flat, miss_d;
  logic [DEN_W-1:0]         span_d, diff_d, den_d;
  logic [DIV_W-1:0]         num_d;
  logic signed [TEMP_W-1:0] base_d;

  always_comb begin
    if (!to_code_q) begin
      at_end = idx_q == IDX_W'(N_ENT - 1);  // final entry never tested
      hit    = cur_code >= code_q;
      exact  = cur_code == code_q;
      zspan  = 1'b0;
      span_d = DEN_W'(cur_temp - prv_temp);
      diff_d = DEN_W'(code_q - prv_code);
      den_d  = DEN_W'(cur_code - prv_code);
      base_d = (exact || at_end) ? cur_temp : prv_temp;
      miss_d = 1'b0;
    end else begin
      at_end = idx_q == IDX_W'(N_ENT);
      hit    = cur_temp >= temp_q;
      exact  = cur_temp == temp_q;
      zspan  = cur_temp == prv_temp;     // flat clamp segment below T_MIN
      span_d = DEN_W'(cur_code - prv_code);
      diff_d = DEN_W'(temp_q - prv_temp);
      den_d  = DEN_W'(cur_temp - prv_temp);
      base_d = exact ? TEMP_W'(cur_code) : TEMP_W'(prv_code);
      miss_d = at_end;
    end
    settle = at_end || hit;
    flat   = at_end || exact || zspan;
    num_d  = flat ? '0 : DIV_W'(span_d) * DIV_W'(diff_d);
    if (flat) den_d = DEN_W'(1);
  end

  logic             div_start, div_done;
  logic [DIV_W-1:0] quot;
  logic signed [TEMP_W-1:0] res;

  assign div_start = (st_q == ST_SEARCH) && settle;
  assign res       = base_q + $signed(TEMP_W'(quot));

  tsc_divider #(.NUM_W(DIV_W), .DEN_W(DEN_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .num_i(num_d), .den_i(den_d), .done_o(div_done), .quot_o(quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; to_code_q <= 1'b0; miss_q <= 1'b0; done_q <= 1'b0;
      fail_q <= 1'b0; code_q <= '0; code_res_q <= '0; temp_q <= '0;
      base_q <= '0; temp_res_q <= '0; idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          to_code_q <= to_code_i;
          code_q    <= code_i;
          temp_q    <= temp_i;
          idx_q     <= IDX_W'(1);
          st_q      <= ST_SEARCH;
        end
        ST_SEARCH: if (settle) begin
          base_q <= base_d;
          miss_q <= miss_d;
          st_q   <= ST_DIV;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
        ST_DIV: if (div_done) begin
          if (to_code_q) begin
            code_res_q <= miss_q ? '1 : res[CODE_W-1:0];
            fail_q     <= miss_q;
          end else begin
            temp_res_q <= res;
            fail_q     <= 1'b0;
          end
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = st_q != ST_IDLE;
  assign done_o = done_q;
  assign temp_o = temp_res_q;
  assign code_o = code_res_q;
  assign fail_o = fail_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_at_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_busy_from_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !div_done) |=> busy_o);
  p_fail_sentinel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> code_o == '1);
  p_temp_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($signed(temp_o) >= T_MIN && $signed(temp_o) <= T_MAX));
  p_idx_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH) |-> (idx_q >= IDX_W'(1) && idx_q <= IDX_W'(N_ENT)));
endmodule

// File: tb/test_tsc_convert.sv
module test_tsc_convert;
  logic        clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, to_code_i = 1'b0;
  logic [11:0] code_i = '0;
  logic [31:0] temp_i = '0;
  logic        busy_o, done_o, fail_o;
  logic [31:0] temp_o;
  logic [11:0] code_o;

  int n_chk = 0, n_bad = 0;

  always #10ns clk_i = ~clk_i;

  tsc_convert i_tsc_convert (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .to_code_i(to_code_i),
    .code_i(code_i), .temp_i(temp_i), .busy_o(busy_o), .done_o(done_o),
    .temp_o(temp_o), .code_o(code_o), .fail_o(fail_o)
  );

  // {to_code, operand, expected, expected fail}
  localparam int NV = 24;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 32'd470,  32'sd0,       1'b0},  // R1
    {1'b0, 32'd402, -32'sd40000,   1'b0},  // R1
    {1'b0, 32'd685,  32'sd125000,  1'b0},  // R1
    {1'b0, 32'd474,  32'sd2500,    1'b0},  // R2
    {1'b0, 32'd403, -32'sd39375,   1'b0},  // R2
    {1'b0, 32'd600,  32'sd75625,   1'b0},  // R2
    {1'b0, 32'd420, -32'sd29375,   1'b0},  // R2
    {1'b0, 32'd488,  32'sd10555,   1'b0},  // R2 truncation
    {1'b0, 32'd100, -32'sd40000,   1'b0},  // R3
    {1'b0, 32'd0,   -32'sd40000,   1'b0},  // R3
    {1'b0, 32'd686,  32'sd125000,  1'b0},  // R3
    {1'b0, 32'd4095, 32'sd125000,  1'b0},  // R3
    {1'b1, 32'sd0,       32'd470,  1'b0},  // R4
    {1'b1, -32'sd40000,  32'd402,  1'b0},  // R4
    {1'b1, 32'sd125000,  32'd685,  1'b0},  // R4
    {1'b1, 32'sd2500,    32'd474,  1'b0},  // R5
    {1'b1, 32'sd1,       32'd470,  1'b0},  // R5
    {1'b1, 32'sd9999,    32'd486,  1'b0},  // R5
    {1'b1, -32'sd1,      32'd469,  1'b0},  // R5
    {1'b1, 32'sd124999,  32'd684,  1'b0},  // R5
    {1'b1, 32'sd125001,  32'hFFF,  1'b1},  // R6
    {1'b1, 32'h7FFFFFFF, 32'hFFF,  1'b1},  // R6
    {1'b1, -32'sd40001,  32'd0,    1'b0},  // R7
    {1'b1, 32'h80000000, 32'd0,    1'b0}   // R7
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic convert(input logic dir, input logic [31:0] val, output int lat);
    @(negedge clk_i);
    to_code_i = dir; code_i = val[11:0]; temp_i = val; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!done_o && lat < 500);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, lat_a;
    logic [11:0] held_code;
    bit extra;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !fail_o && temp_o == '0 && code_o == '0,
          "R8 reset state", {busy_o, done_o, fail_o}, 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      convert(VEC[v][65], VEC[v][64:33], lat);
      if (!VEC[v][65]) begin
        check($signed(temp_o) == $signed(VEC[v][32:1]), "R1 R2 R3 code->temp",
              $signed(temp_o), $signed(VEC[v][32:1]));
        check(fail_o == 1'b0, "R6 fail clear on code->temp", fail_o, 0);
      end else begin
        check(code_o == VEC[v][12:1], "R4 R5 R6 R7 temp->code", code_o, VEC[v][12:1]);
        check(fail_o == VEC[v][0], "R6 fail flag", fail_o, VEC[v][0]);
      end
    end

    // R9 fixed latency from the settled index
    convert(1'b0, 32'd402, lat_a);
    check(lat_a == 34, "R9 latency first entry", lat_a, 34);
    convert(1'b0, 32'd685, lat);
    check(lat == 67, "R9 latency last tested entry", lat, 67);
    convert(1'b1, 32'sd125001, lat);
    check(lat == 69, "R9 latency off table", lat, 69);

    // R8 busy window and request ignored while busy
    convert(1'b1, 32'sd2500, lat);
    held_code = code_o;
    @(negedge clk_i);
    to_code_i = 1'b0; code_i = 12'd474; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check(busy_o == 1'b1, "R8 busy after accept", busy_o, 1);
    repeat (5) @(negedge clk_i);
    to_code_i = 1'b1; temp_i = 32'sd125001; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 500) begin
      check(busy_o == 1'b1, "R8 busy until done", busy_o, 1);
      @(negedge clk_i);
      lat++;
    end
    check(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
    check($signed(temp_o) == 2500, "R8 first request result", $signed(temp_o), 2500);
    check(code_o == held_code && fail_o == 1'b0, "R8 ignored request left code",
          code_o, held_code);
    extra = 1'b0;
    repeat (80) begin
      @(negedge clk_i);
      if (done_o) extra = 1'b1;
    end
    check(!extra, "R8 no done for ignored request", extra, 0);
    check(code_o == held_code, "R8 code unchanged after ignore", code_o, held_code);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule